// File: doc/BRIEF.md
# Sleep Wakeup Interrupt Monitor

This block keeps watch over a set of external interrupt pins while the main processor is asleep. It raises a wake request when an enabled pin shows a qualifying event. It also raises one when a programmed absolute wake time is reached. Each pin can be set to fire on a rising edge, a falling edge, both, or neither. With no edge selected, the pin fires on a level of programmable polarity.

Software programs the block through a simple word-addressed register bus, one register group after another. It then arms the monitor with a single doorbell write. After waking, software reads the latched pending bits to learn which pins caused the wake, and clears them.

The wake time is compared against a free-running 64-bit tick counter supplied from outside. Software derives the absolute value from the sleep duration before arming.

Top module: `wake_monitor`

## Requirements
- R1: The register space has `W = ceil(NUM_PINS/32)` words per group, with `NUM_PINS > 32` so that `W >= 2`. The group order is: wake time (0), enable (1), falling select (2), rising select (3), polarity (4), status (5), and the word address is `group*W + sub`. Pin p sits at bit p%32 of word p/32 in every per-pin group. The doorbell word is at address `6*W`. The enable, select and polarity words read back what was last written.
- R2: After reset, the wake time reads all ones, the enable, select, polarity and status words read zero, the monitor is disarmed and `wakeReq` is low.
- R3: A pin with its rising select bit set records an event on a 0-to-1 change of its synchronised input. A pin change is latched into status on the third rising clock edge after it, through two synchroniser flops and one history flop.
- R4: A pin with its falling select bit set records an event on a 1-to-0 change. Both selects together record either change. A pin whose only select is rising ignores falling changes, and the reverse holds too.
- R5: A pin with both select bits clear is level sensitive. It records an event while its synchronised input equals its polarity bit (1 = active high, 0 = active low). For edge-selected pins the polarity bit has no effect.
- R6: Pending bits set only for enabled pins and only while the monitor is armed. They stay set until cleared.
- R7: Writing zero to a status word clears every pending bit of that word. Writing a non-zero value has no effect.
- R8: The wake time is 64 bits, with the low half in wake-time word 0 and the high half in word 1. The timer wake asserts one clock after `timeNow >= wakeTime`, unless the wake time is all ones.
- R9: Writing the doorbell word with bit `DOORBELL_BIT` set arms the monitor. Reading that word returns the armed flag at the same bit. A doorbell write with that bit clear does nothing.
- R10: `wakeReq` is high whenever any pending bit is set or the timer wake holds. While it is high the monitor disarms, and arming requests are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pinIn | input | NUM_PINS | Asynchronous interrupt pins |
| timeNow | input | 64 | Free-running tick counter |
| busWrEn | input | 1 | Register write strobe |
| busAddr | input | ADDR_W | Word address for read and write |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for `busAddr` (combinational) |
| wakeReq | output | 1 | Wake request |

## Verification
The bench builds the block with `NUM_PINS = 40` and `DOORBELL_BIT = 5`. That gives two words per group, a partly filled second word, and a doorbell bit away from bit zero, so address arithmetic and bit placement mistakes show up.

The sweep covers every pin, crossed with all four edge-select settings, both polarities and both transition directions. For each case the expected pending word and wake state are derived arithmetically from the mode rules. Directed cases cover the timer compare across the word boundary, the all-ones disable, sticky pending after disarm, and status clearing.

// File: rtl/wake_monitor_pkg.sv
package wake_monitor_pkg;

  typedef enum logic [2:0] {
    GRP_TIME   = 3'd0,
    GRP_ENABLE = 3'd1,
    GRP_FALL   = 3'd2,
    GRP_RISE   = 3'd3,
    GRP_POL    = 3'd4,
    GRP_STATUS = 3'd5,
    GRP_DOOR   = 3'd6,
    GRP_NONE   = 3'd7
  } regGroup_t;

  localparam int SUB_FIELD_W = 8;

  typedef struct packed {
    logic                   wrStrobe;
    regGroup_t              group;
    logic [SUB_FIELD_W-1:0] sub;
    logic                   armed;
  } ctrlStrobes_t;

endpackage

// File: rtl/wake_ctrl.sv
module wake_ctrl
  import wake_monitor_pkg::*;
#(
  parameter int WORDS        = 2,
  parameter int ADDR_W       = 4,
  parameter int DOORBELL_BIT = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              doorBit,
  input  logic              wakeReq,
  output ctrlStrobes_t      strobes
);

  localparam int DOOR_ADDR = 6 * WORDS;

  logic      armed;
  regGroup_t grp;
  logic [SUB_FIELD_W-1:0] sub;

  always_comb begin
    if (int'(busAddr) < DOOR_ADDR) begin
      grp = regGroup_t'(3'(int'(busAddr) / WORDS));
      sub = SUB_FIELD_W'(int'(busAddr) % WORDS);
    end else if (int'(busAddr) == DOOR_ADDR) begin
      grp = GRP_DOOR;
      sub = '0;
    end else begin
      grp = GRP_NONE;
      sub = '0;
    end
  end

  // A pending wake takes priority over an arming request.
  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b0;
    end else if (wakeReq) begin
      armed <= 1'b0;
    end else if (busWrEn && grp == GRP_DOOR && doorBit) begin
      armed <= 1'b1;
    end
  end

  always_comb begin
    strobes.wrStrobe = busWrEn;
    strobes.group    = grp;
    strobes.sub      = sub;
    strobes.armed    = armed;
  end

endmodule

// File: rtl/wake_datapath.sv
module wake_datapath
  import wake_monitor_pkg::*;
#(
  parameter int NUM_PINS     = 40,
  parameter int WORDS        = 2,
  parameter int DOORBELL_BIT = 0
) (
  input  logic                  clk,
  input  logic                  rst,
  input  ctrlStrobes_t          strobes,
  input  logic [NUM_PINS-1:0]   pinIn,
  input  logic [63:0]           timeNow,
  input  logic [31:0]           busWrData,
  output logic [31:0]           busRdData,
  output logic [WORDS*32-1:0]   pendVec,
  output logic [WORDS*32-1:0]   enVec,
  output logic [63:0]           wakeTime,
  output logic                  timeHit,
  output logic                  wakeReq
);

  localparam int VEC_BITS = WORDS * 32;

  logic [31:0] enW   [WORDS];
  logic [31:0] fallW [WORDS];
  logic [31:0] riseW [WORDS];
  logic [31:0] polW  [WORDS];
  logic [31:0] pendW [WORDS];
  logic [31:0] evtW  [WORDS];
  logic [31:0] timeLo, timeHi;

  logic [NUM_PINS-1:0] syncA, syncB, prevB;
  logic [VEC_BITS-1:0] fallVec, riseVec, polVec, evtVec;
  logic [WORDS-1:0]    wrSel;
  logic                clearReq;

  assign wakeTime = {timeHi, timeLo};
  assign clearReq = (busWrData == 32'd0);

  always_comb begin
    for (int w = 0; w < WORDS; w++) begin
      wrSel[w] = strobes.wrStrobe && (strobes.sub == SUB_FIELD_W'(w));
      enVec[w*32 +: 32]   = enW[w];
      fallVec[w*32 +: 32] = fallW[w];
      riseVec[w*32 +: 32] = riseW[w];
      polVec[w*32 +: 32]  = polW[w];
      pendVec[w*32 +: 32] = pendW[w];
      evtW[w]             = evtVec[w*32 +: 32];
    end
  end

  // Per-pin event decode: edge modes when any select is set, else level.
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic isEdge, rose, fell, lvl;
    assign isEdge = riseVec[p] | fallVec[p];
    assign rose   = syncB[p] & ~prevB[p];
    assign fell   = ~syncB[p] & prevB[p];
    assign lvl    = (syncB[p] == polVec[p]);
    assign evtVec[p] = strobes.armed & enVec[p] &
                       (isEdge ? ((riseVec[p] & rose) | (fallVec[p] & fell)) : lvl);
  end
  if (VEC_BITS > NUM_PINS) begin : g_pad
    assign evtVec[VEC_BITS-1:NUM_PINS] = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int w = 0; w < WORDS; w++) begin
        enW[w]   <= '0;
        fallW[w] <= '0;
        riseW[w] <= '0;
        polW[w]  <= '0;
        pendW[w] <= '0;
      end
      timeLo  <= '1;
      timeHi  <= '1;
      timeHit <= 1'b0;
      syncA   <= '0;
      syncB   <= '0;
      prevB   <= '0;
    end else begin
      syncA   <= pinIn;
      syncB   <= syncA;
      prevB   <= syncB;
      timeHit <= (wakeTime != '1) && (timeNow >= wakeTime);
      for (int w = 0; w < WORDS; w++) begin
        if (wrSel[w] && strobes.group == GRP_ENABLE) enW[w]   <= busWrData;
        if (wrSel[w] && strobes.group == GRP_FALL)   fallW[w] <= busWrData;
        if (wrSel[w] && strobes.group == GRP_RISE)   riseW[w] <= busWrData;
        if (wrSel[w] && strobes.group == GRP_POL)    polW[w]  <= busWrData;
        pendW[w] <= ((wrSel[w] && strobes.group == GRP_STATUS && clearReq) ?
                     32'd0 : pendW[w]) | evtW[w];
      end
      if (strobes.wrStrobe && strobes.group == GRP_TIME && strobes.sub == '0)
        timeLo <= busWrData;
      if (strobes.wrStrobe && strobes.group == GRP_TIME && strobes.sub == SUB_FIELD_W'(1))
        timeHi <= busWrData;
    end
  end

  always_comb begin
    busRdData = '0;
    case (strobes.group)
      GRP_TIME: begin
        if (strobes.sub == '0) busRdData = timeLo;
        else if (strobes.sub == SUB_FIELD_W'(1)) busRdData = timeHi;
      end
      GRP_DOOR: busRdData = 32'(strobes.armed) << DOORBELL_BIT;
      GRP_NONE: busRdData = '0;
      default: begin
        for (int w = 0; w < WORDS; w++) begin
          if (strobes.sub == SUB_FIELD_W'(w)) begin
            case (strobes.group)
              GRP_ENABLE: busRdData = enW[w];
              GRP_FALL:   busRdData = fallW[w];
              GRP_RISE:   busRdData = riseW[w];
              GRP_POL:    busRdData = polW[w];
              default:    busRdData = pendW[w];
            endcase
          end
        end
      end
    endcase
  end

  assign wakeReq = (|pendVec) | timeHit;

endmodule

// File: rtl/wake_monitor.sv
module wake_monitor
  import wake_monitor_pkg::*;
#(
  parameter int NUM_PINS     = 40,
  parameter int DOORBELL_BIT = 0,
  parameter int WORDS        = (NUM_PINS + 31) / 32,
  parameter int ADDR_W       = $clog2(6 * WORDS + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] pinIn,
  input  logic [63:0]         timeNow,
  input  logic                busWrEn,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [31:0]         busWrData,
  output logic [31:0]         busRdData,
  output logic                wakeReq
);

  localparam int VEC_BITS = WORDS * 32;

  ctrlStrobes_t        strobes;
  logic [VEC_BITS-1:0] pendVec, enVec;
  logic [63:0]         wakeTime;
  logic                timeHit;

  wake_ctrl #(
    .WORDS(WORDS), .ADDR_W(ADDR_W), .DOORBELL_BIT(DOORBELL_BIT)
  ) ctrl_i (
    .clk(clk), .rst(rst), .busWrEn(busWrEn), .busAddr(busAddr),
    .doorBit(busWrData[DOORBELL_BIT]), .wakeReq(wakeReq), .strobes(strobes)
  );

  wake_datapath #(
    .NUM_PINS(NUM_PINS), .WORDS(WORDS), .DOORBELL_BIT(DOORBELL_BIT)
  ) dp_i (
    .clk(clk), .rst(rst), .strobes(strobes), .pinIn(pinIn), .timeNow(timeNow),
    .busWrData(busWrData), .busRdData(busRdData), .pendVec(pendVec),
    .enVec(enVec), .wakeTime(wakeTime), .timeHit(timeHit), .wakeReq(wakeReq)
  );

endmodule

// File: rtl/wake_monitor_chk.sv
module wake_monitor_chk #(
  parameter int VEC_BITS = 64
) (
  input logic                clk,
  input logic                rst,
  input logic                busWrEn,
  input logic                wakeReq,
  input logic                armed,
  input logic [VEC_BITS-1:0] pendVec,
  input logic [VEC_BITS-1:0] enVec,
  input logic [63:0]         wakeTime,
  input logic                timeHit
);

  // R10
  wake_disarms_chk: assert property (@(posedge clk) disable iff (rst)
    wakeReq |=> !armed);

  // R6
  pend_needs_arm_chk: assert property (@(posedge clk) disable iff (rst)
    (|(pendVec & ~$past(pendVec))) |-> $past(armed));

  // R6
  pend_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
    ((pendVec & ~$past(pendVec) & ~$past(enVec)) == '0));

  // R8
  timer_off_chk: assert property (@(posedge clk) disable iff (rst)
    (&wakeTime) |=> !timeHit);

  // R9
  arm_from_write_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(armed) |-> $past(busWrEn));

endmodule

bind wake_monitor wake_monitor_chk #(.VEC_BITS(VEC_BITS)) chk_i (
  .clk(clk), .rst(rst), .busWrEn(busWrEn), .wakeReq(wakeReq),
  .armed(strobes.armed), .pendVec(pendVec), .enVec(enVec),
  .wakeTime(wakeTime), .timeHit(timeHit)
);

// File: tb/wake_monitor_tb_top.sv
`timescale 1ns/100ps
module wake_monitor_tb_top;

  localparam int NP = 40;
  localparam int DB = 5;
  localparam int W  = (NP + 31) / 32;
  localparam int AW = $clog2(6 * W + 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NP-1:0] pins = '0;
  logic [63:0]   tnow = '0;
  logic          wrEn = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          wake;

  int nChecks = 0;
  int nFail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  wake_monitor #(.NUM_PINS(NP), .DOORBELL_BIT(DB)) dut_i (
    .clk(clk), .rst(rst), .pinIn(pins), .timeNow(tnow), .busWrEn(wrEn),
    .busAddr(addr), .busWrData(wdata), .busRdData(rdata), .wakeReq(wake)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int g, input int s, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = AW'(g * W + s); wdata = d;
    @(negedge clk);
    wrEn = 1'b0; wdata = '0;
  endtask

  task automatic rd(input int g, input int s, output logic [31:0] d);
    @(negedge clk);
    addr = AW'(g * W + s);
    #1 d = rdata;
  endtask

  function automatic logic [31:0] bitIn(input int p, input int s, input bit on);
    return (on && p / 32 == s) ? (32'd1 << (p % 32)) : 32'd0;
  endfunction

  // One sweep case: pin p, mode bit0 = rising, bit1 = falling.
  task automatic trial(input int p, input int mode, input int pol, input int dir);
    logic [31:0] v;
    bit rs, fs, isEdge, s0, s1, pre, post;
    string tag;
    rs = mode[0]; fs = mode[1]; isEdge = rs | fs;
    s0 = !dir[0]; s1 = dir[0];
    tag = isEdge ? (dir[0] ? "R3" : "R4") : "R5";
    for (int s = 0; s < W; s++) begin
      wr(1, s, bitIn(p, s, 1'b1));
      wr(2, s, bitIn(p, s, fs));
      wr(3, s, bitIn(p, s, rs));
      wr(4, s, bitIn(p, s, pol[0]));
    end
    pins = {NP{s0}};
    cyc(4);
    for (int s = 0; s < W; s++) wr(5, s, 32'd0);
    cyc(1);
    wr(6, 0, 32'd1 << DB);
    cyc(5);
    pre = !isEdge && (s0 == pol[0]);
    rd(5, p / 32, v);
    chk($sformatf("%s pre pin%0d m%0d p%0d", tag, p, mode, pol), v, bitIn(p, p / 32, pre));
    chk("R10 wake pre", wake, pre);
    if (!pre) begin
      pins = {NP{s1}};
      cyc(5);
      post = isEdge ? (dir[0] ? rs : fs) : (s1 == pol[0]);
      rd(5, p / 32, v);
      chk($sformatf("%s post pin%0d m%0d p%0d d%0d", tag, p, mode, pol, dir), v,
          bitIn(p, p / 32, post));
      chk("R10 wake post", wake, post);
      rd(6, 0, v);
      chk("R10 armed after", v, post ? 32'd0 : (32'd1 << DB));
    end
  endtask

  initial begin
    #(5.0 * 190000);
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    cyc(3);
    rst = 1'b0;
    cyc(1);

    // R2 reset values
    for (int s = 0; s < W; s++) begin
      rd(0, s, v); chk("R2 time reset", v, 32'hFFFF_FFFF);
      for (int g = 1; g < 6; g++) begin
        rd(g, s, v); chk("R2 group reset", v, 32'd0);
      end
    end
    rd(6, 0, v); chk("R2 armed reset", v, 32'd0);
    chk("R2 wake reset", wake, 1'b0);

    // R1 readback of per-pin groups
    for (int g = 1; g < 5; g++)
      for (int s = 0; s < W; s++) wr(g, s, 32'h5A00_0000 | (g << 8) | s);
    for (int g = 1; g < 5; g++)
      for (int s = 0; s < W; s++) begin
        rd(g, s, v); chk("R1 readback", v, 32'h5A00_0000 | (g << 8) | s);
      end
    for (int g = 1; g < 5; g++)
      for (int s = 0; s < W; s++) wr(g, s, 32'd0);

    // R9 doorbell without the bit, R6 unarmed pin is ignored
    wr(1, 0, 32'd1); wr(3, 0, 32'd1);
    wr(6, 0, ~(32'd1 << DB));
    rd(6, 0, v); chk("R9 no arm", v, 32'd0);
    pins[0] = 1'b1; cyc(5);
    rd(5, 0, v); chk("R6 unarmed", v, 32'd0);
    chk("R6 unarmed wake", wake, 1'b0);
    pins[0] = 1'b0; cyc(4);

    // R6 sticky, disarm stops new bits; R7 clear semantics
    wr(1, 0, 32'h18); wr(3, 0, 32'h18);
    wr(6, 0, 32'd1 << DB);
    rd(6, 0, v); chk("R9 armed", v, 32'd1 << DB);
    pins[3] = 1'b1; cyc(5);
    rd(5, 0, v); chk("R3 pin3", v, 32'h8);
    chk("R10 wake pin3", wake, 1'b1);
    rd(6, 0, v); chk("R10 disarmed", v, 32'd0);
    wr(6, 0, 32'd1 << DB);
    rd(6, 0, v); chk("R10 arm blocked while waking", v, 32'd0);
    pins[4] = 1'b1; cyc(5);
    rd(5, 0, v); chk("R6 sticky no new", v, 32'h8);
    wr(5, 0, 32'h1);
    rd(5, 0, v); chk("R7 nonzero ignored", v, 32'h8);
    wr(5, 0, 32'd0);
    rd(5, 0, v); chk("R7 cleared", v, 32'd0);
    cyc(1); chk("R7 wake drops", wake, 1'b0);
    pins = '0; wr(1, 0, 32'd0); wr(3, 0, 32'd0); cyc(4);

    // R8 timer
    wr(0, 0, 32'h10); wr(0, 1, 32'h1);
    rd(0, 0, v); chk("R1 time lo", v, 32'h10);
    rd(0, 1, v); chk("R1 time hi", v, 32'h1);
    tnow = 64'h0000_0000_FFFF_FFFF; cyc(3);
    chk("R8 hi below", wake, 1'b0);
    tnow = 64'h0000_0001_0000_000F; cyc(3);
    chk("R8 one below", wake, 1'b0);
    wr(6, 0, 32'd1 << DB);
    tnow = 64'h0000_0001_0000_0010; cyc(2);
    chk("R8 equal", wake, 1'b1);
    rd(6, 0, v); chk("R10 timer disarms", v, 32'd0);
    tnow = 64'h0000_0002_0000_0000; cyc(2);
    chk("R8 hi above", wake, 1'b1);
    wr(0, 0, 32'hFFFF_FFFF); wr(0, 1, 32'hFFFF_FFFF);
    tnow = '1; cyc(3);
    chk("R8 all ones off", wake, 1'b0);
    tnow = '0;

    // R3 R4 R5 sweep: all pins, modes, polarities, directions
    for (int p = 0; p < NP; p++)
      for (int m = 0; m < 4; m++)
        for (int pl = 0; pl < 2; pl++)
          for (int d = 0; d < 2; d++) trial(p, m, pl, d);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

endmodule